// File: doc/BRIEF.md
# Aligned SPI Memory-Access Master

This block moves an arbitrary run of bytes between a local byte buffer and a 32-bit remote address space over SPI. A request names a start address, a byte count and a direction. The block splits the request into a series of SPI transactions. For each transaction it picks the widest access size that keeps the remote address naturally aligned. It sends a command byte and the address, adds the dummy bytes the target expects, and reorders bytes so that the little-endian local buffer and the word-wise MSB-first wire image agree.

The local side is a plain byte port. The block presents a buffer index. Write data is read back combinationally on `bufRdData`, and read data comes out on a one-cycle write strobe. The serial side runs SPI mode 0. The SCLK half-period is set by a parameter, and the default gives 6.25 MHz from a 200 MHz clock, which is close to the 6 MHz target.

Top module: `spi_xfer_master`

## Requirements
- R1: The command byte carries the access kind in bits [2:1] (0 = 2-byte, 1 = 4-byte, 2 = burst) and the direction in bit 0 (1 = write), giving codes 0x0/0x1, 0x2/0x3 and 0x4/0x5. A 2-byte access is used when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain.
- R2: If R1 does not apply, a 4-byte access is used when the address modulo 8 is 4 or at most 6 bytes remain. Otherwise a burst moves the remaining count rounded down to a multiple of 8, limited to BURST_MAX (240).
- R3: Each transaction opens with 5 header bytes: the command byte, then the 32-bit address of the first byte not yet moved, most significant byte first.
- R4: A read sends 4 zero dummy bytes between the header and the data. A write sends one zero dummy byte after its data.
- R5: Data byte k of a transaction, counted on the wire, pairs with local index (bytes already moved) + (k XOR (W-1)). W is 2, 4 or 8 for the three access kinds, and bits go out MSB first.
- R6: A request with an odd address, or a read with an odd length, raises `err` for one cycle. It produces no chip-select activity and no `done`.
- R7: A write of odd length sends one extra zero byte after the last buffer byte, and the selection in R1 and R2 then sees the padded length.
- R8: `csN` stays low for the whole of each transaction and rises between transactions. `sclk` idles low while `csN` is high. MOSI is stable while SCLK is high, and every transaction carries a whole number of bytes.
- R9: `done` pulses for one cycle after the last transaction of a request. `busy` is high from acceptance until then.
- R10: A request with length zero pulses `done` without any SPI activity.
- R11: A 260-byte read starting at an address ending in 0x02 uses exactly six transactions, moving 2, 4, 240, 8, 4 and 2 bytes in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write remote memory, 0 = read |
| reqAddr | input | 32 | Remote start byte address |
| reqLen | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment pulse |
| bufAddr | output | LEN_W | Local buffer byte index |
| bufRdData | input | 8 | Local byte at bufAddr (combinational) |
| bufWrEn | output | 1 | Write strobe for read data |
| bufWrData | output | 8 | Byte to store at bufAddr |
| sclk | output | 1 | Serial clock, mode 0 |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest cases to reach from the ports are the splits in which all three access kinds appear in one request and a burst hits its cap. A behavioural target memory decodes every transaction's header and logs its kind, address and length. The bench sweeps every 8-byte alignment against a range of lengths in both directions, plus a 260-byte read and a 250-byte write that force the 240-byte limit. Each logged sequence is compared with a split computed arithmetically from the selection rule. The moved data is then compared byte for byte, which exposes any mistake in the word reversal.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [1:0] KIND_HALF  = 2'd0;
  localparam logic [1:0] KIND_WORD  = 2'd1;
  localparam logic [1:0] KIND_BURST = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_HDR,
    ST_DUMR,
    ST_DATA,
    ST_DUMW,
    ST_END,
    ST_GAP
  } spim_state_e;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic       loadByte;
    logic [7:0] txByte;
  } spim_strobe_t;

endpackage

// File: rtl/spim_cmd_sel.sv
module spim_cmd_sel
  import spim_pkg::*;
#(
  parameter int OFF_W     = 13,
  parameter int BURST_MAX = 240
) (
  input  logic [2:0]       alignOff,
  input  logic [OFF_W-1:0] remain,
  output logic [1:0]       kind,
  output logic [7:0]       chunkLen,
  output logic [2:0]       wordMask
);

  localparam logic [OFF_W-1:0] CAP = OFF_W'(BURST_MAX);

  logic [OFF_W-1:0] rounded;

  always_comb begin
    rounded = remain & ~OFF_W'(7);
    if (alignOff == 3'd2 || alignOff == 3'd6 || remain == OFF_W'(2)) begin
      kind     = KIND_HALF;
      chunkLen = 8'd2;
      wordMask = 3'd1;
    end else if (alignOff == 3'd4 || remain <= OFF_W'(6)) begin
      kind     = KIND_WORD;
      chunkLen = 8'd4;
      wordMask = 3'd3;
    end else begin
      kind     = KIND_BURST;
      wordMask = 3'd7;
      chunkLen = (rounded > CAP) ? 8'(BURST_MAX) : 8'(rounded);
    end
  end

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  spim_strobe_t strb,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         byteDone,
  output logic [7:0]   rxByte
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [2:0]       bitCnt;
  logic             active;
  logic             phaseHigh;
  logic             tick;

  assign tick = active && (divCnt == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      bitCnt    <= '0;
      active    <= 1'b0;
      phaseHigh <= 1'b0;
      sclk      <= 1'b0;
      byteDone  <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strb.loadByte) begin
        txShift   <= strb.txByte;
        active    <= 1'b1;
        bitCnt    <= '0;
        phaseHigh <= 1'b0;
        divCnt    <= '0;
        sclk      <= 1'b0;
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          if (!phaseHigh) begin
            sclk      <= 1'b1;
            phaseHigh <= 1'b1;
            rxShift   <= {rxShift[6:0], miso};
          end else begin
            sclk      <= 1'b0;
            phaseHigh <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign mosi   = txShift[7];
  assign rxByte = rxShift;

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int BURST_MAX = 240,
  parameter int HALF_DIV  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  input  logic [7:0]       bufRdData,
  output spim_strobe_t     strb,
  output logic             csN,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] bufAddr,
  output logic             bufWrEn,
  output logic [7:0]       bufWrData
);

  localparam int OFF_W   = LEN_W + 1;
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  spim_state_e      state;
  logic [31:0]      curAddr;
  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] lenPad;
  logic [LEN_W-1:0] lenRaw;
  logic             isWrite;
  logic [1:0]       kind;
  logic [7:0]       chunkLen;
  logic [2:0]       wordMask;
  logic [7:0]       byteIdx;
  logic             waiting;
  logic [GAP_W-1:0] gapCnt;

  logic [OFF_W-1:0] remain;
  logic [1:0]       selKind;
  logic [7:0]       selLen;
  logic [2:0]       selMask;
  logic [OFF_W-1:0] localIdx;
  logic             inPhase;
  logic [7:0]       phaseLast;
  logic             misaligned;

  assign remain = lenPad - offset;

  spim_cmd_sel #(
    .OFF_W    (OFF_W),
    .BURST_MAX(BURST_MAX)
  ) u_sel (
    .alignOff(curAddr[2:0]),
    .remain  (remain),
    .kind    (selKind),
    .chunkLen(selLen),
    .wordMask(selMask)
  );

  assign localIdx   = offset + OFF_W'(byteIdx ^ {5'b0, wordMask});
  assign bufAddr    = localIdx[LEN_W-1:0];
  assign misaligned = reqAddr[0] || (!reqWrite && reqLen[0]);
  assign inPhase    = (state == ST_HDR) || (state == ST_DUMR) ||
                      (state == ST_DATA) || (state == ST_DUMW);

  always_comb begin
    case (state)
      ST_HDR:  phaseLast = 8'd4;
      ST_DUMR: phaseLast = 8'd3;
      ST_DATA: phaseLast = chunkLen - 8'd1;
      default: phaseLast = 8'd0;
    endcase
  end

  always_comb begin
    strb.loadByte = inPhase && !waiting;
    strb.txByte   = 8'h00;
    if (state == ST_HDR) begin
      case (byteIdx[2:0])
        3'd0:    strb.txByte = {5'b0, kind, isWrite};
        3'd1:    strb.txByte = curAddr[31:24];
        3'd2:    strb.txByte = curAddr[23:16];
        3'd3:    strb.txByte = curAddr[15:8];
        default: strb.txByte = curAddr[7:0];
      endcase
    end else if (state == ST_DATA && isWrite) begin
      strb.txByte = (localIdx < {1'b0, lenRaw}) ? bufRdData : 8'h00;
    end
  end

  assign bufWrEn   = (state == ST_DATA) && !isWrite && byteDone;
  assign bufWrData = rxByte;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curAddr  <= '0;
      offset   <= '0;
      lenPad   <= '0;
      lenRaw   <= '0;
      isWrite  <= 1'b0;
      kind     <= '0;
      chunkLen <= '0;
      wordMask <= '0;
      byteIdx  <= '0;
      waiting  <= 1'b0;
      gapCnt   <= '0;
      csN      <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (misaligned) begin
              err <= 1'b1;
            end else if (reqLen == '0) begin
              done <= 1'b1;
            end else begin
              curAddr <= reqAddr;
              offset  <= '0;
              lenRaw  <= reqLen;
              lenPad  <= {1'b0, reqLen} + OFF_W'(reqLen[0]);
              isWrite <= reqWrite;
              state   <= ST_SEL;
            end
          end
        end
        ST_SEL: begin
          kind     <= selKind;
          chunkLen <= selLen;
          wordMask <= selMask;
          byteIdx  <= '0;
          waiting  <= 1'b0;
          csN      <= 1'b0;
          state    <= ST_HDR;
        end
        ST_HDR, ST_DUMR, ST_DATA, ST_DUMW: begin
          if (strb.loadByte) waiting <= 1'b1;
          if (byteDone) begin
            waiting <= 1'b0;
            if (byteIdx == phaseLast) begin
              byteIdx <= '0;
              case (state)
                ST_HDR:  state <= isWrite ? ST_DATA : ST_DUMR;
                ST_DUMR: state <= ST_DATA;
                ST_DATA: state <= isWrite ? ST_DUMW : ST_END;
                default: state <= ST_END;
              endcase
            end else begin
              byteIdx <= byteIdx + 8'd1;
            end
          end
        end
        ST_END: begin
          csN     <= 1'b1;
          curAddr <= curAddr + {24'b0, chunkLen};
          offset  <= offset + OFF_W'(chunkLen);
          gapCnt  <= '0;
          state   <= ST_GAP;
        end
        default: begin
          if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
            if (offset == lenPad) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_SEL;
            end
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spim_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int BURST_MAX = 240,
  parameter int HALF_DIV  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] bufAddr,
  input  logic [7:0]       bufRdData,
  output logic             bufWrEn,
  output logic [7:0]       bufWrData,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso
);

  spim_strobe_t strb;
  logic         byteDone;
  logic [7:0]   rxByte;

  spim_ctrl #(
    .LEN_W    (LEN_W),
    .BURST_MAX(BURST_MAX),
    .HALF_DIV (HALF_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .bufRdData(bufRdData),
    .strb     (strb),
    .csN      (csN),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .bufAddr  (bufAddr),
    .bufWrEn  (bufWrEn),
    .bufWrData(bufWrData)
  );

  spim_dpath #(
    .HALF_DIV(HALF_DIV)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .byteDone(byteDone),
    .rxByte  (rxByte)
  );

endmodule

// File: rtl/spi_xfer_master_chk.sv
module spim_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err,
  input logic bufWrEn
);

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R8

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));  // R8

  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);  // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (csN && !done));  // R6

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);  // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_RX_IN_TXN: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> !csN);  // R5

endmodule

bind spi_xfer_master spim_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .sclk   (sclk),
  .mosi   (mosi),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .bufWrEn(bufWrEn)
);

// File: tb/spi_xfer_master_tb.sv
`timescale 1ns/1ps
module spi_xfer_master_tb;

  localparam int LEN_W = 9;
  localparam int BMAX  = 240;
  localparam logic [31:0] BASE = 32'h6003_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic busy, done, err, bufWrEn, sclk, csN, mosi;
  logic miso = 1'b0;
  logic [LEN_W-1:0] bufAddr;
  logic [7:0] bufRdData, bufWrData;

  always #2.5 clk = ~clk;

  spi_xfer_master #(.LEN_W(LEN_W), .BURST_MAX(BMAX), .HALF_DIV(1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .busy(busy), .done(done), .err(err),
    .bufAddr(bufAddr), .bufRdData(bufRdData), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // local byte buffer
  logic [7:0] lbuf [0:511];
  assign bufRdData = lbuf[bufAddr];
  always @(posedge clk) if (bufWrEn) lbuf[bufAddr] <= bufWrData;

  // behavioural target memory
  logic [7:0] tmem [0:4095];
  logic [7:0] tBytes [0:255];
  logic [7:0] tShift = '0;
  int tBits = 0;
  bit armed = 0;
  logic [7:0]  logCmd  [0:63];
  logic [31:0] logAddr [0:63];
  int          logLen  [0:63];
  int logN = 0, frameErr = 0, dummyErr = 0, idleViol = 0;
  int nChecks = 0, nFail = 0;

  function automatic int maskOf(logic [7:0] c);
    case (c[2:1])
      2'd0: return 1;
      2'd1: return 3;
      default: return 7;
    endcase
  endfunction

  always @(negedge csN) if (armed) begin
    tBits = 0;
    miso = 1'b0;
  end

  always @(posedge sclk) if (armed && !csN) begin
    tShift = {tShift[6:0], mosi};
    tBits++;
    if (tBits % 8 == 0 && tBits / 8 <= 256) tBytes[tBits/8-1] = tShift;
  end

  always @(negedge sclk) if (armed && !csN) begin : drv
    int bn, bi;
    logic [31:0] ad;
    bn = tBits / 8;
    bi = 7 - (tBits % 8);
    ad = {tBytes[1], tBytes[2], tBytes[3], tBytes[4]};
    if (bn >= 9 && !tBytes[0][0])
      miso = tmem[(ad + 32'((bn - 9) ^ maskOf(tBytes[0]))) % 4096][bi];
    else
      miso = 1'b0;
  end

  always @(posedge csN) if (armed) begin : commit
    int nb, mk;
    logic [31:0] ad;
    nb = tBits / 8;
    if (tBits % 8 != 0) frameErr++;
    ad = {tBytes[1], tBytes[2], tBytes[3], tBytes[4]};
    mk = maskOf(tBytes[0]);
    logCmd[logN]  = tBytes[0];
    logAddr[logN] = ad;
    if (tBytes[0][0]) begin
      logLen[logN] = nb - 6;
      for (int d = 0; d < nb - 6; d++) tmem[(ad + 32'(d ^ mk)) % 4096] = tBytes[5+d];
      if (tBytes[nb-1] != 8'h00) dummyErr++;
    end else begin
      logLen[logN] = nb - 9;
    end
    if (logN < 63) logN++;
  end

  always @(negedge clk) if (armed && csN && sclk) idleViol++;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReq(bit wr, logic [31:0] a, int len, output bit gotDone, output bit gotErr);
    logN = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 20000 && !gotDone && !gotErr; i++) begin
      if (done) gotDone = 1;
      if (err) gotErr = 1;
      if (!gotDone && !gotErr) @(negedge clk);
    end
  endtask

  // expected split, computed from R1/R2 with padded length (R7)
  task automatic chkSeq(string req, bit wr, logic [31:0] a, int len);
    int rem, off, n, k, cl, al;
    bit ok;
    rem = len + (len % 2); off = 0; n = 0; ok = 1;
    while (rem > 0) begin
      al = int'((a + 32'(off)) % 8);
      if (al == 2 || al == 6 || rem == 2) begin k = 0; cl = 2; end
      else if (al == 4 || rem <= 6) begin k = 1; cl = 4; end
      else begin k = 2; cl = (rem / 8) * 8; if (cl > BMAX) cl = BMAX; end
      if (n >= logN) ok = 0;
      else if (logCmd[n] != 8'(k * 2 + int'(wr)) || logAddr[n] != a + 32'(off) ||
               logLen[n] != cl) ok = 0;
      n++; off += cl; rem -= cl;
    end
    chk(ok && n == logN, req, "transaction split/header", logN, n);
  endtask

  initial begin : main
    bit gd, ge;
    bit ok;
    int badIdx;
    int exp11 [6] = '{2, 4, 240, 8, 4, 2};
    logic [31:0] a;

    for (int i = 0; i < 4096; i++) tmem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    for (int i = 0; i < 512; i++) lbuf[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    armed = 1;
    chk(csN === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "R9", "reset state", int'(busy), 0);

    // R11: 260-byte read from offset 2 with all three kinds and a capped burst
    a = BASE + 32'h102;
    for (int j = 0; j < 264; j++) lbuf[j] = 8'hEE;
    doReq(0, a, 260, gd, ge);
    chk(gd && !ge, "R11", "260-byte read completes", int'(gd), 1);
    ok = (logN == 6);
    for (int t = 0; t < 6 && ok; t++) if (logLen[t] != exp11[t]) ok = 0;
    chk(ok, "R11", "six-transaction order 2,4,240,8,4,2", logN, 6);
    chkSeq("R3", 0, a, 260);
    badIdx = -1;
    for (int j = 0; j < 260; j++) if (lbuf[j] != tmem[(a + 32'(j)) % 4096] && badIdx < 0) badIdx = j;
    chk(badIdx < 0 && lbuf[260] == 8'hEE, "R5", "260-byte read data", badIdx, -1);

    // read sweep: every alignment, many lengths (R1 R2 R3 R4 R5)
    for (int off = 0; off < 8; off += 2) begin
      for (int len = 2; len <= 24; len += 2) begin
        a = BASE + 32'h300 + 32'(off);
        for (int j = 0; j < len + 2; j++) lbuf[j] = 8'hEE;
        doReq(0, a, len, gd, ge);
        chk(gd && !ge, "R9", "read done", int'(gd), 1);
        chkSeq("R1", 0, a, len);
        badIdx = -1;
        for (int j = 0; j < len; j++) if (lbuf[j] != tmem[(a + 32'(j)) % 4096] && badIdx < 0) badIdx = j;
        chk(badIdx < 0 && lbuf[len] == 8'hEE, "R5", "read data reorder", badIdx, -1);
      end
    end

    // write sweep: every alignment, odd and even lengths (R2 R4 R5 R7)
    for (int off = 0; off < 8; off += 2) begin
      for (int len = 1; len <= 17; len++) begin
        a = BASE + 32'h500 + 32'(off);
        for (int j = 0; j < 20; j++) tmem[(a + 32'(j)) % 4096] = 8'h55;
        for (int j = 0; j < len; j++) lbuf[j] = 8'(j * 13 + off * 5 + len);
        for (int j = len; j < len + 4; j++) lbuf[j] = 8'hC3;
        doReq(1, a, len, gd, ge);
        chk(gd && !ge, "R9", "write done", int'(gd), 1);
        chkSeq("R2", 1, a, len);
        badIdx = -1;
        for (int j = 0; j < len; j++) if (tmem[(a + 32'(j)) % 4096] != lbuf[j] && badIdx < 0) badIdx = j;
        chk(badIdx < 0, "R5", "write data reorder", badIdx, -1);
        if (len % 2 == 1)
          chk(tmem[(a + 32'(len)) % 4096] == 8'h00, "R7", "pad byte zero",
              int'(tmem[(a + 32'(len)) % 4096]), 0);
        chk(tmem[(a + 32'(len + len % 2)) % 4096] == 8'h55, "R7", "no write past padded end",
            int'(tmem[(a + 32'(len + len % 2)) % 4096]), 8'h55);
      end
    end
    chk(dummyErr == 0, "R4", "write trailing dummy byte zero", dummyErr, 0);

    // burst cap on a write (R2)
    a = BASE + 32'h800;
    for (int j = 0; j < 250; j++) lbuf[j] = 8'(j + 1);
    doReq(1, a, 250, gd, ge);
    chkSeq("R2", 1, a, 250);
    chk(logN == 3 && logLen[0] == 240, "R2", "burst limited to 240", logLen[0], 240);

    // misaligned requests (R6)
    doReq(0, BASE + 32'h11, 4, gd, ge);
    chk(ge && !gd && logN == 0, "R6", "odd read address rejected", logN, 0);
    doReq(0, BASE + 32'h10, 5, gd, ge);
    chk(ge && !gd && logN == 0, "R6", "odd read length rejected", logN, 0);
    doReq(1, BASE + 32'h13, 6, gd, ge);
    chk(ge && !gd && logN == 0, "R6", "odd write address rejected", logN, 0);
    repeat (4) @(negedge clk);
    chk(logN == 0 && done == 1'b0, "R6", "no later activity after error", logN, 0);

    // zero length (R10)
    doReq(1, BASE, 0, gd, ge);
    chk(gd && !ge && logN == 0, "R10", "zero length done without SPI", logN, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done is a single pulse", int'(done), 0);

    chk(frameErr == 0, "R8", "whole bytes per transaction", frameErr, 0);
    chk(idleViol == 0, "R8", "sclk low while deselected", idleViol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule